// File: doc/BRIEF.md
# Dual Alarm Comparator with Interrupt Steering

This block watches a running calendar time and raises alarms. It holds two independent alarm sets. Each set has four compare fields: seconds, minutes, hours and day. Once per second the time counter pulses an update strobe. On that strobe each alarm set is compared against the current time. When an alarm matches, its status flag is latched. The flag stays set until software clears it.

Each compare field carries its own don't-care bit. A field with that bit set takes no part in the comparison. An alarm with every field excluded fires on every update. Each alarm has an interrupt enable bit. A steering bit decides how the two alarms reach the interrupt pins. In split mode each alarm drives its own active-low pin. In shared mode both alarms are combined on the first pin, and the second pin stays idle.

The surrounding chip provides the current time, the update strobe and the register writes. It reads the flags and the interrupt lines back.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset both status flags are 0, both interrupt enables are 0, the steering bit is 0 (shared mode), every alarm field is 8'h00, and both interrupt outputs are high.
- R2: On a clock edge where `tick_i` is 1, flag n sets if every non-excluded field of alarm n equals the matching 7-bit field of `now_i`. Field index 0 is seconds, 1 is minutes, 2 is hours and 3 is day. Field k of `now_i` lies at bits [7k+6:7k]. A write selects an alarm with `wr_alarm_i` and a field with `wr_field_i`.
- R3: Bit 7 of an alarm field is a don't-care bit that removes that field from the comparison. An alarm with bit 7 set in all four fields matches on every update strobe.
- R4: A flag never sets on an edge where `tick_i` is 0, whatever the current time is.
- R5: A set flag holds until a `clr_i[n]` pulse clears it on the next edge. If the clear and a new match for the same alarm arrive on the same edge, the flag stays set.
- R6: A flag whose enable bit (`ctl_ie_i[n]`, latched by `ctl_wr_i`) is 0 still sets, but it asserts no interrupt output.
- R7: With the steering bit at 1, enabled flag 0 drives `irq_a_n_o` low and enabled flag 1 drives `irq_b_n_o` low.
- R8: With the steering bit at 0, `irq_a_n_o` is low when either enabled flag is set, and `irq_b_n_o` stays high.
- R9: A field write on the same edge as an update strobe does not affect that comparison. The comparison uses the field value held before the write.
- R10: A match of one alarm never sets the other alarm's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Once-per-second update strobe |
| now_i | input | 28 | Current time as four 7-bit fields: seconds, minutes, hours, day |
| wr_en_i | input | 1 | Alarm field write strobe |
| wr_alarm_i | input | 1 | Alarm select for the write |
| wr_field_i | input | 2 | Field select for the write |
| wr_data_i | input | 8 | Field value; bit 7 is the don't-care bit |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_ie_i | input | 2 | Interrupt enables, one per alarm |
| ctl_split_i | input | 1 | Steering bit: 1 gives separate pins, 0 gives a shared pin |
| clr_i | input | 2 | Flag clear strobes, one per alarm |
| flag_o | output | 2 | Alarm status flags |
| irq_a_n_o | output | 1 | First interrupt line, active low |
| irq_b_n_o | output | 1 | Second interrupt line, active low |

## Verification
The status flags change on the clock edge that samples the strobe, match or clear that causes the change. They are therefore due one cycle after the stimulus. The interrupt lines follow the flags, enables and steering bit through logic only, so they are due in the same cycle as the flag or control change. The bench drives every input on a falling edge and checks the outputs on the next falling edge, after exactly one rising edge has passed. Reset release passes through a two-stage synchronizer, so the bench waits three cycles before the first check.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALARMS     = 2;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 4;

  typedef struct packed {
    logic              split;
    logic [ALARMS-1:0] ie;
  } irq_ctl_t;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/alm_set.sv
module alm_set #(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4,
  parameter int FSEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [FSEL_W-1:0]                 wr_field_i,
  input  logic [FIELD_W-1:0]                wr_data_i,
  input  logic [NUM_FIELDS*(FIELD_W-1)-1:0] now_i,
  output logic                              hit_o
);
  localparam int VAL_W = FIELD_W - 1;

  logic [FIELD_W-1:0]    fld_q [NUM_FIELDS];
  logic [FIELD_W-1:0]    fld_d [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fhit;

  always_comb begin
    for (int k = 0; k < NUM_FIELDS; k++) begin
      fld_d[k] = (wr_en_i && (wr_field_i == FSEL_W'(k))) ? wr_data_i : fld_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_FIELDS; k++) fld_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_FIELDS; k++) fld_q[k] <= fld_d[k];
    end
  end

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_cmp
    assign fhit[k] = fld_q[k][FIELD_W-1] |
                     (fld_q[k][VAL_W-1:0] == now_i[k*VAL_W +: VAL_W]);
  end

  assign hit_o = &fhit;
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = (tick_i & hit_i) | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alm_route.sv
module alm_route (
  input  logic       split_i,
  input  logic [1:0] flag_i,
  input  logic [1:0] ie_i,
  output logic       irq_a_n_o,
  output logic       irq_b_n_o
);
  logic [1:0] gated;

  always_comb begin
    gated     = flag_i & ie_i;
    irq_a_n_o = ~(gated[0] | (~split_i & gated[1]));
    irq_b_n_o = ~(split_i & gated[1]);
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alm_pkg::*;
#(
  parameter int FIELD_W    = alm_pkg::FIELD_W,
  parameter int NUM_FIELDS = alm_pkg::NUM_FIELDS,
  parameter int FSEL_W     = $clog2(NUM_FIELDS),
  parameter int NOW_W      = NUM_FIELDS * (FIELD_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NOW_W-1:0]  now_i,
  input  logic              wr_en_i,
  input  logic              wr_alarm_i,
  input  logic [FSEL_W-1:0] wr_field_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic              ctl_wr_i,
  input  logic [ALARMS-1:0] ctl_ie_i,
  input  logic              ctl_split_i,
  input  logic [ALARMS-1:0] clr_i,
  output logic [ALARMS-1:0] flag_o,
  output logic              irq_a_n_o,
  output logic              irq_b_n_o
);
  logic              rst_sync_n;
  irq_ctl_t          ctl_d, ctl_q;
  logic [ALARMS-1:0] hit;
  logic [ALARMS-1:0] ie_q;
  logic              split_q;

  alm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr_i) begin
      ctl_d.ie    = ctl_ie_i;
      ctl_d.split = ctl_split_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctl_q <= '0;
    else             ctl_q <= ctl_d;
  end

  assign ie_q    = ctl_q.ie;
  assign split_q = ctl_q.split;

  for (genvar a = 0; a < ALARMS; a++) begin : g_alarm
    alm_set #(
      .FIELD_W    (FIELD_W),
      .NUM_FIELDS (NUM_FIELDS),
      .FSEL_W     (FSEL_W)
    ) u_set (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_en_i    (wr_en_i && (wr_alarm_i == 1'(a))),
      .wr_field_i (wr_field_i),
      .wr_data_i  (wr_data_i),
      .now_i      (now_i),
      .hit_o      (hit[a])
    );

    alm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick_i (tick_i),
      .hit_i  (hit[a]),
      .clr_i  (clr_i[a]),
      .flag_o (flag_o[a])
    );
  end

  alm_route u_route (
    .split_i   (split_q),
    .flag_i    (flag_o),
    .ie_i      (ie_q),
    .irq_a_n_o (irq_a_n_o),
    .irq_b_n_o (irq_b_n_o)
  );
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic [1:0] clr_i,
  input logic [1:0] flag_i,
  input logic [1:0] ie_i,
  input logic       split_i,
  input logic       irq_a_n,
  input logic       irq_b_n
);
  // R5: a set flag survives any edge without its clear
  assert_flag0_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i[0] && !clr_i[0]) |=> flag_i[0]);
  assert_flag1_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i[1] && !clr_i[1]) |=> flag_i[1]);
  // R5: a clear with no update strobe empties the flag
  assert_flag0_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[0] && !tick_i) |=> !flag_i[0]);
  // R4: no update strobe, no new flag
  assert_no_set_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !flag_i[1]) |=> !flag_i[1]);
  // R6: all enables off keeps both lines idle
  assert_gated_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_i == 2'b00) |-> (irq_a_n && irq_b_n));
  // R8: shared mode never uses the second line
  assert_shared_b_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !split_i |-> irq_b_n);
  // R7: split mode puts enabled alarm 1 on the second line
  assert_split_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && ie_i[1] && flag_i[1]) |-> !irq_b_n);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick_i  (tick_i),
  .clr_i   (clr_i),
  .flag_i  (flag_o),
  .ie_i    (ie_q),
  .split_i (split_q),
  .irq_a_n (irq_a_n_o),
  .irq_b_n (irq_b_n_o)
);

// File: tb/alarm_irq_unit_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [27:0] now_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_alarm_i = 1'b0;
  logic [1:0]  wr_field_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        ctl_wr_i = 1'b0;
  logic [1:0]  ctl_ie_i = '0;
  logic        ctl_split_i = 1'b0;
  logic [1:0]  clr_i = '0;
  logic [1:0]  flag_o;
  logic        irq_a_n_o, irq_b_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_irq_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .now_i       (now_i),
    .wr_en_i     (wr_en_i),
    .wr_alarm_i  (wr_alarm_i),
    .wr_field_i  (wr_field_i),
    .wr_data_i   (wr_data_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_ie_i    (ctl_ie_i),
    .ctl_split_i (ctl_split_i),
    .clr_i       (clr_i),
    .flag_o      (flag_o),
    .irq_a_n_o   (irq_a_n_o),
    .irq_b_n_o   (irq_b_n_o)
  );

  function automatic logic [27:0] mk_now(int s, int m, int h, int d);
    return {7'(d), 7'(h), 7'(m), 7'(s)};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(string req, int fl, int a, int b);
    check(req, "flags", int'(flag_o), fl);
    check(req, "irq_a_n", int'(irq_a_n_o), a);
    check(req, "irq_b_n", int'(irq_b_n_o), b);
  endtask

  task automatic wr_field(int al, int f, int d);
    wr_en_i = 1'b1; wr_alarm_i = 1'(al); wr_field_i = 2'(f); wr_data_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic prog(int al, int s, int m, int h, int d);
    wr_field(al, 0, s); wr_field(al, 1, m); wr_field(al, 2, h); wr_field(al, 3, d);
  endtask

  task automatic set_ctl(int ie, int split);
    ctl_wr_i = 1'b1; ctl_ie_i = 2'(ie); ctl_split_i = 1'(split);
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  task automatic do_tick(logic [27:0] t);
    now_i = t; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic do_clear(int m);
    clr_i = 2'(m);
    @(negedge clk);
    clr_i = '0;
  endtask

  task automatic t_reset;
    check_out("R1", 0, 1, 1);
  endtask

  task automatic t_match;
    prog(0, 12, 34, 5, 3);
    do_tick(mk_now(12, 34, 5, 3));
    check_out("R2", 1, 1, 1);          // R6: enables still 0
    do_clear(3);
    check("R5", "flags after clear", int'(flag_o), 0);
    do_tick(mk_now(12, 35, 5, 3));
    check("R2", "minute mismatch", int'(flag_o), 0);
    do_tick(mk_now(12, 34, 5, 4));
    check("R2", "day mismatch", int'(flag_o), 0);
    check("R10", "alarm1 untouched", int'(flag_o[1]), 0);
  endtask

  task automatic t_no_tick;
    now_i = mk_now(12, 34, 5, 3);
    repeat (5) @(negedge clk);
    check("R4", "no strobe no flag", int'(flag_o), 0);
  endtask

  task automatic t_mask;
    prog(1, 8'h80, 8'h80, 8'h80, 8'h80);
    do_tick(mk_now(1, 2, 3, 4));
    check("R3", "all masked fires", int'(flag_o), 2);
    do_clear(3);
    wr_field(0, 0, 8'h80);
    do_tick(mk_now(59, 34, 5, 3));
    check("R3", "seconds masked", int'(flag_o), 3);
    do_clear(3);
  endtask

  task automatic t_hold;
    do_tick(mk_now(59, 34, 5, 3));
    repeat (3) @(negedge clk);
    check("R5", "flags held", int'(flag_o), 3);
    clr_i = 2'b01; now_i = mk_now(59, 34, 5, 3); tick_i = 1'b1;
    @(negedge clk);
    clr_i = '0; tick_i = 1'b0;
    check("R5", "clear loses to match", int'(flag_o), 3);
    do_clear(3);
    check("R5", "clear both", int'(flag_o), 0);
  endtask

  task automatic t_route;
    set_ctl(3, 1);
    wr_field(0, 0, 12);
    do_tick(mk_now(1, 2, 3, 4));
    check_out("R7", 2, 1, 0);
    do_clear(3);
    wr_field(1, 0, 0);
    do_tick(mk_now(12, 34, 5, 3));
    check_out("R7", 1, 0, 1);
    do_clear(3);
    wr_field(1, 0, 8'h80);
    set_ctl(3, 0);
    do_tick(mk_now(1, 2, 3, 4));
    check_out("R8", 2, 0, 1);
    set_ctl(1, 0);
    check_out("R6", 2, 1, 1);
    do_clear(3);
  endtask

  task automatic t_write_tick;
    now_i = mk_now(12, 34, 5, 3); tick_i = 1'b1;
    wr_en_i = 1'b1; wr_alarm_i = 1'b0; wr_field_i = 2'd0; wr_data_i = 8'd20;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R9", "old value compared", int'(flag_o[0]), 1);
    do_clear(3);
    do_tick(mk_now(12, 34, 5, 3));
    check("R9", "old value gone", int'(flag_o[0]), 0);
    do_tick(mk_now(20, 34, 5, 3));
    check("R9", "new value matches", int'(flag_o[0]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_match();
    t_no_tick();
    t_mask();
    t_hold();
    t_route();
    t_write_tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule